// File: doc/BRIEF.md
# Suspend-Aware DRAM Refresh Scheduler

This block produces the periodic refresh requests for a DRAM array. It keeps them going both in normal running, when refresh is timed from ticks of the host clock, and in suspend, when the host and bus clocks may stop and refresh is timed from ticks of a slow clock that keeps running. Both timebases reach the block as single-cycle enable ticks in one design clock. The DRAM command sequencing that acts on each request lies outside the block.

An active-low suspend-status input is sampled every cycle. The first cycle it is seen low, the block enters its suspend state. It clears its normal-refresh-enable bit and moves refresh onto the suspend timebase. When the status input goes high again, the block leaves its suspend state, but refresh stays on the suspend timebase. It moves back to host timing only when software pulses the enable-set input. Every change of timebase issues one request at once and restarts the interval. This keeps the gap between two requests within its limit during the changeover.

Each timebase has its own divider, `HOST_DIV` or `SUSP_DIV`. The two are chosen so that the refresh rate in time is the same in both modes.

Top module: `rfsh_sched`

## Requirements
- R1: During reset and directly after it, `rfsh_req_o` is 0, `mode_o` is 1 (suspend timebase), `nref_en_o` is 0 and `in_susp_o` is 0.
- R2: `in_susp_o` equals the inverse of `susp_stat_n_i` as sampled at the previous clock edge.
- R3: In a cycle where `susp_stat_n_i` is low and `in_susp_o` is still 0 (suspend entry), the next edge clears `nref_en_o` and sets `mode_o` to 1.
- R4: While `mode_o` is 1, a request is issued on the edge of every `SUSP_DIV`-th `susp_tick_i` since the last request, and `host_tick_i` has no effect.
- R5: While `mode_o` is 0, a request is issued on the edge of every `HOST_DIV`-th `host_tick_i` since the last request, and `susp_tick_i` has no effect.
- R6: A pulse on `nref_set_i` sets `nref_en_o` and makes `mode_o` 0 at the next edge. A suspend entry in the same cycle takes priority and leaves the bit clear. `mode_o` is always the inverse of `nref_en_o`.
- R7: On every edge where `mode_o` changes, `rfsh_req_o` is 1 and the interval count starts afresh in the new timebase.
- R8: `in_susp_o` stays 1 while `susp_stat_n_i` stays low, even after normal refresh has been re-enabled.
- R9: With host ticks every 2 cycles and suspend ticks every 8 cycles, no gap between requests exceeds 32 cycles across a full sequence of suspend, resume and re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_tick_i | input | 1 | Enable tick from the host timebase |
| susp_tick_i | input | 1 | Enable tick from the always-running suspend timebase |
| susp_stat_n_i | input | 1 | Suspend status, active low |
| nref_set_i | input | 1 | Software pulse that sets the normal-refresh-enable bit |
| rfsh_req_o | output | 1 | One-cycle refresh request |
| mode_o | output | 1 | Active timebase: 0 host, 1 suspend |
| in_susp_o | output | 1 | Block is in its suspend state |
| nref_en_o | output | 1 | Normal-refresh-enable bit |

## Verification
A wrong enable bit or suspend flag shows on `mode_o`, `nref_en_o` or `in_susp_o` at the very next edge. A missed switch request shows as an absent `rfsh_req_o` in that same cycle. A count held in the wrong timebase, or a counter that was not restarted, first shows as a request that comes early or late. That appears within one refresh interval, at most 32 cycles here, and the gap monitor reports a stretched interval as soon as the late request arrives.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic {
    TB_HOST = 1'b0,
    TB_SUSP = 1'b1
  } tbase_e;

  // Timebase selected by the normal-refresh-enable bit.
  function automatic tbase_e tbase_of(input logic nref_en);
    return nref_en ? TB_HOST : TB_SUSP;
  endfunction

  // Next value of the enable bit: suspend entry clears it and wins over a set pulse.
  function automatic logic nref_next(input logic cur, input logic entry, input logic set_pulse);
    if (entry)          return 1'b0;
    else if (set_pulse) return 1'b1;
    else                return cur;
  endfunction

  // Counter width that can hold div-1 for the larger divider.
  function automatic int cnt_width(input int div_a, input int div_b);
    int m;
    m = (div_a > div_b) ? div_a : div_b;
    return (m > 1) ? $clog2(m) : 1;
  endfunction

endpackage

// File: rtl/rfsh_susp_track.sv
module rfsh_susp_track
  import rfsh_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   susp_stat_n,
  input  logic   nref_set,
  output logic   in_susp,
  output logic   nref_en,
  output logic   entry_evt,
  output logic   switch_evt,
  output tbase_e mode_cur,
  output tbase_e mode_nxt
);

  logic nref_d;

  always_comb begin
    entry_evt  = ~susp_stat_n & ~in_susp;
    nref_d     = nref_next(nref_en, entry_evt, nref_set);
    switch_evt = nref_d ^ nref_en;
    mode_cur   = tbase_of(nref_en);
    mode_nxt   = tbase_of(nref_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_susp <= 1'b0;
      nref_en <= 1'b0;
    end else begin
      in_susp <= ~susp_stat_n;
      nref_en <= nref_d;
    end
  end

endmodule

// File: rtl/rfsh_interval_cnt.sv
module rfsh_interval_cnt
  import rfsh_pkg::*;
#(
  parameter int HOST_DIV = 16,
  parameter int SUSP_DIV = 4,
  localparam int CNT_W = cnt_width(HOST_DIV, SUSP_DIV)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  tbase_e mode_cur,
  input  tbase_e mode_nxt,
  input  logic   switch_evt,
  input  logic   host_tick,
  input  logic   susp_tick,
  output logic   expire_evt,
  output logic   req
);

  localparam logic [CNT_W-1:0] HOST_RLD = CNT_W'(HOST_DIV - 1);
  localparam logic [CNT_W-1:0] SUSP_RLD = CNT_W'(SUSP_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic             tick_sel;
  logic             fire;

  function automatic logic [CNT_W-1:0] reload_for(input tbase_e m);
    return (m == TB_SUSP) ? SUSP_RLD : HOST_RLD;
  endfunction

  always_comb begin
    tick_sel   = (mode_cur == TB_SUSP) ? susp_tick : host_tick;
    expire_evt = tick_sel && (cnt == '0);
    fire       = switch_evt || expire_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= SUSP_RLD;
      req <= 1'b0;
    end else begin
      req <= fire;
      if (fire)          cnt <= reload_for(mode_nxt);
      else if (tick_sel) cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int HOST_DIV = 16,
  parameter int SUSP_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_tick_i,
  input  logic susp_tick_i,
  input  logic susp_stat_n_i,
  input  logic nref_set_i,
  output logic rfsh_req_o,
  output logic mode_o,
  output logic in_susp_o,
  output logic nref_en_o
);

  tbase_e mode_cur;
  tbase_e mode_nxt;
  logic   entry_evt;
  logic   switch_evt;
  logic   expire_evt;

  rfsh_susp_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .susp_stat_n(susp_stat_n_i),
    .nref_set   (nref_set_i),
    .in_susp    (in_susp_o),
    .nref_en    (nref_en_o),
    .entry_evt  (entry_evt),
    .switch_evt (switch_evt),
    .mode_cur   (mode_cur),
    .mode_nxt   (mode_nxt)
  );

  rfsh_interval_cnt #(
    .HOST_DIV(HOST_DIV),
    .SUSP_DIV(SUSP_DIV)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_cur  (mode_cur),
    .mode_nxt  (mode_nxt),
    .switch_evt(switch_evt),
    .host_tick (host_tick_i),
    .susp_tick (susp_tick_i),
    .expire_evt(expire_evt),
    .req       (rfsh_req_o)
  );

  assign mode_o = logic'(mode_cur);

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic host_tick_i,
  input logic susp_tick_i,
  input logic susp_stat_n_i,
  input logic nref_set_i,
  input logic rfsh_req_o,
  input logic mode_o,
  input logic in_susp_o,
  input logic nref_en_o,
  input logic entry_evt,
  input logic switch_evt
);

  // R2
  insusp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (in_susp_o == !$past(susp_stat_n_i)));

  // R3
  entry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_evt |=> (!nref_en_o && mode_o));

  // R6
  nref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nref_set_i && !entry_evt) |=> (nref_en_o && !mode_o));

  // R7
  switch_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_evt |=> rfsh_req_o);

  // R4
  req_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req_o |-> ((mode_o != $past(mode_o)) ||
                    ($past(mode_o) ? $past(susp_tick_i) : $past(host_tick_i))));

  // R8
  hold_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_susp_o && !susp_stat_n_i) |=> in_susp_o);

endmodule

bind rfsh_sched rfsh_sched_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_tick_i  (host_tick_i),
  .susp_tick_i  (susp_tick_i),
  .susp_stat_n_i(susp_stat_n_i),
  .nref_set_i   (nref_set_i),
  .rfsh_req_o   (rfsh_req_o),
  .mode_o       (mode_o),
  .in_susp_o    (in_susp_o),
  .nref_en_o    (nref_en_o),
  .entry_evt    (entry_evt),
  .switch_evt   (switch_evt)
);

// File: tb/rfsh_sched_bench.sv
module rfsh_sched_bench;

  localparam int HOST_DIV = 16;
  localparam int SUSP_DIV = 4;
  localparam int HOST_P   = 2;
  localparam int SUSP_P   = 8;
  localparam int MAX_GAP  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_tick_i = 1'b0;
  logic susp_tick_i = 1'b0;
  logic susp_stat_n_i = 1'b1;
  logic nref_set_i = 1'b0;
  logic rfsh_req_o, mode_o, in_susp_o, nref_en_o;

  always #5 clk = ~clk;

  rfsh_sched #(.HOST_DIV(HOST_DIV), .SUSP_DIV(SUSP_DIV)) u_rfsh_sched (
    .clk(clk), .rst_n(rst_n), .host_tick_i(host_tick_i), .susp_tick_i(susp_tick_i),
    .susp_stat_n_i(susp_stat_n_i), .nref_set_i(nref_set_i), .rfsh_req_o(rfsh_req_o),
    .mode_o(mode_o), .in_susp_o(in_susp_o), .nref_en_o(nref_en_o)
  );

  typedef struct {
    logic  req;
    logic  mode;
    logic  insusp;
    logic  nref;
    string tag;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   fails   = 0;
  int   cyc     = 0;
  bit   host_en = 1'b1;
  bit   done    = 1'b0;

  // Reference state, kept as an up-count of ticks since the last request.
  bit m_nref = 1'b0;
  bit m_insusp = 1'b0;
  int m_ticks = 0;

  task automatic step(input string tag);
    bit   ht, st, entry, nn, req;
    exp_t e;
    ht = host_en && (cyc % HOST_P == 0);
    st = (cyc % SUSP_P == 0);
    host_tick_i = ht;
    susp_tick_i = st;
    entry = !susp_stat_n_i && !m_insusp;
    nn = entry ? 1'b0 : (nref_set_i ? 1'b1 : m_nref);
    req = 1'b0;
    if (nn != m_nref) begin
      req = 1'b1;
      m_ticks = 0;
    end else if (m_nref ? ht : st) begin
      if (m_ticks + 1 == (m_nref ? HOST_DIV : SUSP_DIV)) begin
        req = 1'b1;
        m_ticks = 0;
      end else m_ticks++;
    end
    m_nref = nn;
    m_insusp = !susp_stat_n_i;
    e.req = req; e.mode = !nn; e.insusp = m_insusp; e.nref = nn; e.tag = tag;
    q.push_back(e);
    cyc++;
    @(posedge clk);
    #2;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic pulse_set(input string tag);
    nref_set_i = 1'b1;
    step(tag);
    nref_set_i = 1'b0;
  endtask

  // Monitor: pops the expected item after each edge and compares.
  int gap = 0;
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (rfsh_req_o !== e.req || mode_o !== e.mode || in_susp_o !== e.insusp ||
          nref_en_o !== e.nref) begin
        fails++;
        $display("FAIL %s cyc=%0d req/mode/insusp/nref actual=%b%b%b%b expected=%b%b%b%b",
                 e.tag, cyc, rfsh_req_o, mode_o, in_susp_o, nref_en_o,
                 e.req, e.mode, e.insusp, e.nref);
      end
    end
    if (rst_n) begin
      gap++;
      if (rfsh_req_o === 1'b1) begin
        vectors++;
        if (gap > MAX_GAP) begin
          fails++;
          $display("FAIL R9 gap actual=%0d expected<=%0d", gap, MAX_GAP);
        end
        gap = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    vectors++;
    if (rfsh_req_o !== 1'b0 || mode_o !== 1'b1 || nref_en_o !== 1'b0 || in_susp_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 req/mode/insusp/nref actual=%b%b%b%b expected=0100",
               rfsh_req_o, mode_o, in_susp_o, nref_en_o);
    end
    rst_n = 1'b1;
    // After reset refresh runs on the suspend timebase; host ticks ignored (R4).
    run(100, "R4");
    // Software re-enables normal refresh: immediate request, host timing (R6 R7).
    pulse_set("R6 R7");
    run(150, "R5");
    // Suspend entry clears the enable bit and switches back (R3 R7).
    susp_stat_n_i = 1'b0;
    run(3, "R3 R7");
    host_en = 1'b0;
    run(150, "R4 R9");
    // Resume: host clocks return, block leaves suspend, timebase stays (R2).
    host_en = 1'b1;
    susp_stat_n_i = 1'b1;
    run(80, "R2 R4");
    pulse_set("R6 R7");
    run(60, "R5 R9");
    // Re-enable during suspend: block stays in suspend state (R8).
    susp_stat_n_i = 1'b0;
    run(20, "R3");
    pulse_set("R8 R6");
    run(60, "R8 R5");
    susp_stat_n_i = 1'b1;
    run(20, "R2");
    // Set pulse in the same cycle as suspend entry: entry wins (R6).
    susp_stat_n_i = 1'b0;
    pulse_set("R6 R3");
    run(40, "R4");
    susp_stat_n_i = 1'b1;
    run(20, "R2");
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule